// File: doc/BRIEF.md
# Register-Access I2C Target with Strap Addressing

This block is an I2C target that runs entirely on a fast system clock. It never uses SCL as a clock. Both bus lines are resynchronised and put through a small majority filter, and every bus event is then derived from the filtered samples. These events are the SCL edges, START and STOP. The block holds four 16-bit registers reached through a 2-bit pointer. A controller can set the pointer, write a register as two bytes with the high byte first, or read a register back in the same byte order. Every completed register write also leaves the block as a one-cycle write strobe that carries the register index and the data, so that the surrounding logic can act on it.

The 7-bit target address comes from a two-bit strap code. The code reports which of four levels the address pin is tied to, and it is used live rather than latched. The block answers the general-call reset command: all registers and the pointer return to their reset values and a power-down flag is raised. It also recognises the high-speed master code without acknowledging it, and reports that condition on a mode flag until the next STOP. SDA is driven open-drain: the output is an enable that pulls the line low. SCL is only ever an input, so the block never stretches the clock.

Top module: `i2cs_top`

## Requirements
- R1: The target address is binary 10010 followed by the two bits of `strapSel`. Code 0 (ground) gives 0x48, 1 (supply) gives 0x49, 2 (tied to SDA) gives 0x4A and 3 (tied to SCL) gives 0x4B. Any other non-general-call address gets no acknowledge. A change of `strapSel` between transfers takes effect without a reset.
- R2: In a write, the byte after the address is the pointer, and bits [1:0] select the register. A write that ends after the pointer byte changes only the pointer. The pointer keeps its value across transfers.
- R3: The two data bytes that follow the pointer are stored high byte first into the selected register, and each byte is acknowledged. The store produces exactly one `regWrEn` pulse, with `regWrAddr` and `regWrData`. A fifth byte in the same write gets no acknowledge.
- R4: In a read (address with R/W=1), the target returns the selected register high byte first, then the low byte. Both bytes come from one snapshot taken when the high byte starts.
- R5: If the controller does not acknowledge the high byte, the target releases SDA and sends nothing more until the next START. A STOP always releases SDA on the following cycle.
- R6: The general-call address 0x00 with R/W=0 is acknowledged, and with R/W=1 it is not. A second byte of 0x06 is acknowledged, returns every register and the pointer to their reset values, and raises `powerDown`. Any other second byte is not acknowledged and has no effect.
- R7: `powerDown` is 0 after reset. It is cleared by a completed register write and is never high in a cycle where `regWrEn` is high.
- R8: An address byte whose upper five bits are 00001 is never acknowledged. It sets `hsMode`, which stays high until the next STOP. A repeated START after it begins normal address reception.
- R9: `sdaOe` changes only while the filtered SCL is low. The acknowledge pull-down starts at the SCL fall after the eighth bit and ends at the next SCL fall.
- R10: After reset, `sdaOe`, `hsMode`, `powerDown` and `regWrEn` are 0, the pointer is 0, and register k holds 0x0A05 + k*0x1010.
- R11: A START seen in the middle of a transfer restarts address reception, and a pointer set before it remains in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Raw SCL line level |
| sdaIn | input | 1 | Raw SDA line level |
| strapSel | input | 2 | Address strap code: 0 ground, 1 supply, 2 SDA, 3 SCL |
| sdaOe | output | 1 | Open-drain SDA pull-down enable |
| hsMode | output | 1 | High when the high-speed master code has been seen, cleared by STOP |
| powerDown | output | 1 | Raised by the general-call reset command |
| regWrEn | output | 1 | One-cycle strobe for a completed register write |
| regWrAddr | output | 2 | Index of the register written |
| regWrData | output | 16 | Value written |

## Verification
Every strap code is tried against all four candidate addresses. This separates a correct address decode from one that ignores the strap or swaps two of its codes. Each register is written under each strap with a value derived arithmetically from the strap and the index, and then read back. A swapped byte order, a pointer mistake or a lost write shows up as a mismatch in both the read data and the write strobe. The general-call byte 0x05 against 0x06, the general-call address with R/W=1, all eight high-speed codes, a read cut short by a missing acknowledge, and a repeated START after a pointer byte each exercise one of the side paths of the control.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  // Strobes the control issues to the datapath, at most one bus event per cycle
  typedef struct packed {
    logic shiftIn;  // sample SDA into the receive byte
    logic ldPtr;    // pointer byte complete
    logic ldMsb;    // high data byte complete
    logic wrReg;    // low data byte complete: commit the register
    logic capTx;    // snapshot the selected register for a read
    logic shiftTx;  // advance the transmit shifter
    logic gcReset;  // general-call reset command accepted
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK
  } state_t;

  localparam logic [7:0] GC_RESET_CMD = 8'h06;
  localparam logic [4:0] HS_CODE_TOP  = 5'b00001;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclF,
  output logic sdaF,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic [FILT_LEN-1:0]    sclHist, sdaHist;
  logic                   sclPrev, sdaPrev;

  function automatic logic majority(input logic [FILT_LEN-1:0] h);
    int n;
    n = 0;
    for (int i = 0; i < FILT_LEN; i++) if (h[i]) n++;
    return n > FILT_LEN / 2;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1; sdaSync <= '1;
      sclHist <= '1; sdaHist <= '1;
      sclF    <= 1'b1; sdaF <= 1'b1;
      sclPrev <= 1'b1; sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclHist <= {sclHist[FILT_LEN-2:0], sclSync[SYNC_STAGES-1]};
      sdaHist <= {sdaHist[FILT_LEN-2:0], sdaSync[SYNC_STAGES-1]};
      sclF    <= majority(sclHist);
      sdaF    <= majority(sdaHist);
      sclPrev <= sclF;
      sdaPrev <= sdaF;
    end
  end

  assign sclRise  = sclF & ~sclPrev;
  assign sclFall  = ~sclF & sclPrev;
  assign startDet = sclF & sclPrev & sdaPrev & ~sdaF;
  assign stopDet  = sclF & sclPrev & ~sdaPrev & sdaF;
endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
#(
  parameter logic [4:0] ADDR_BASE = 5'b10010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaF,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic [1:0] strapSel,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output strobe_t    stb,
  output logic       sdaOe,
  output logic       hsMode
);
  state_t     state;
  logic [3:0] bitCnt;
  logic [1:0] byteIdx;
  logic       isRead, isGc, lastByte, ackDrive, masterAck, lsbSent;

  logic [6:0] myAddr;
  logic       rxDone, addrHs, addrMe, addrGc;

  assign myAddr = {ADDR_BASE, strapSel};
  assign rxDone = sclFall && (bitCnt == 4'd8);
  assign addrHs = rxByte[7:3] == HS_CODE_TOP;
  assign addrMe = rxByte[7:1] == myAddr;
  assign addrGc = (rxByte[7:1] == 7'd0) && !rxByte[0];
  assign sdaOe  = ackDrive | ((state == ST_TX) & ~txBit);

  always_comb begin
    stb = '0;
    if (!startDet && !stopDet) begin
      case (state)
        ST_ADDR: stb.shiftIn = sclRise && (bitCnt < 4'd8);
        ST_RX: begin
          stb.shiftIn = sclRise && (bitCnt < 4'd8);
          if (rxDone) begin
            if (isGc) stb.gcReset = rxByte == GC_RESET_CMD;
            else begin
              stb.ldPtr = byteIdx == 2'd0;
              stb.ldMsb = byteIdx == 2'd1;
              stb.wrReg = byteIdx == 2'd2;
            end
          end
        end
        ST_ADDR_ACK: stb.capTx   = sclFall && isRead;
        ST_TX:       stb.shiftTx = sclFall;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; bitCnt <= '0; byteIdx <= '0;
      isRead <= 1'b0; isGc <= 1'b0; lastByte <= 1'b0;
      ackDrive <= 1'b0; masterAck <= 1'b0; lsbSent <= 1'b0; hsMode <= 1'b0;
    end else if (startDet) begin
      state <= ST_ADDR; bitCnt <= '0; ackDrive <= 1'b0;
    end else if (stopDet) begin
      state <= ST_IDLE; ackDrive <= 1'b0; hsMode <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (sclRise) bitCnt <= bitCnt + 4'd1;
          else if (rxDone) begin
            if (addrHs) begin
              hsMode <= 1'b1;
              state  <= ST_IDLE;
            end else if (addrMe || addrGc) begin
              ackDrive <= 1'b1;
              isRead   <= rxByte[0];
              isGc     <= addrGc;
              state    <= ST_ADDR_ACK;
            end else state <= ST_IDLE;
          end
        end
        ST_ADDR_ACK: if (sclFall) begin
          ackDrive <= 1'b0; bitCnt <= '0; byteIdx <= '0; lsbSent <= 1'b0;
          state    <= isRead ? ST_TX : ST_RX;
        end
        ST_RX: begin
          if (sclRise) bitCnt <= bitCnt + 4'd1;
          else if (rxDone) begin
            if (isGc && rxByte != GC_RESET_CMD) state <= ST_IDLE;
            else begin
              ackDrive <= 1'b1;
              lastByte <= isGc || (byteIdx == 2'd2);
              byteIdx  <= byteIdx + 2'd1;
              state    <= ST_RX_ACK;
            end
          end
        end
        ST_RX_ACK: if (sclFall) begin
          ackDrive <= 1'b0; bitCnt <= '0;
          state    <= lastByte ? ST_IDLE : ST_RX;
        end
        ST_TX: begin
          if (sclRise) bitCnt <= bitCnt + 4'd1;
          else if (sclFall && bitCnt == 4'd8) state <= ST_TX_ACK;
        end
        ST_TX_ACK: begin
          if (sclRise) masterAck <= !sdaF;
          else if (sclFall) begin
            if (masterAck && !lsbSent) begin
              lsbSent <= 1'b1; bitCnt <= '0; state <= ST_TX;
            end else state <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2cs_data.sv
module i2cs_data
  import i2cs_pkg::*;
#(
  parameter int NREG = 4,
  parameter logic [NREG*16-1:0] REG_INIT = 64'h3A35_2A25_1A15_0A05,
  localparam int PTR_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sdaF,
  input  strobe_t          stb,
  output logic [7:0]       rxByte,
  output logic             txBit,
  output logic             regWrEn,
  output logic [PTR_W-1:0] regWrAddr,
  output logic [15:0]      regWrData,
  output logic             powerDown
);
  logic [15:0]      regFile [NREG];
  logic [PTR_W-1:0] ptr;
  logic [7:0]       msbHold;
  logic [15:0]      txShift;
  logic [15:0]      wrValue;

  assign wrValue = {msbHold, rxByte};
  assign txBit   = txShift[15];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic [15:0] r;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                      r <= REG_INIT[k*16 +: 16];
      else if (stb.gcReset)                           r <= REG_INIT[k*16 +: 16];
      else if (stb.wrReg && ptr == PTR_W'(k))         r <= wrValue;
    end
    assign regFile[k] = r;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0; ptr <= '0; msbHold <= '0; txShift <= '1;
      regWrEn <= 1'b0; regWrAddr <= '0; regWrData <= '0; powerDown <= 1'b0;
    end else begin
      regWrEn <= stb.wrReg;
      if (stb.shiftIn) rxByte  <= {rxByte[6:0], sdaF};
      if (stb.ldPtr)   ptr     <= rxByte[PTR_W-1:0];
      if (stb.ldMsb)   msbHold <= rxByte;
      if (stb.capTx)        txShift <= regFile[ptr];
      else if (stb.shiftTx) txShift <= {txShift[14:0], 1'b1};
      if (stb.wrReg) begin
        regWrAddr <= ptr;
        regWrData <= wrValue;
        powerDown <= 1'b0;
      end
      if (stb.gcReset) begin
        ptr       <= '0;
        powerDown <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cs_top.sv
module i2cs_top
  import i2cs_pkg::*;
#(
  parameter int NREG = 4,
  parameter logic [NREG*16-1:0] REG_INIT = 64'h3A35_2A25_1A15_0A05,
  parameter logic [4:0] ADDR_BASE = 5'b10010,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN = 3,
  localparam int PTR_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [1:0]       strapSel,
  output logic             sdaOe,
  output logic             hsMode,
  output logic             powerDown,
  output logic             regWrEn,
  output logic [PTR_W-1:0] regWrAddr,
  output logic [15:0]      regWrData
);
  logic    sclF, sdaF, sclRise, sclFall, startDet, stopDet, txBit;
  logic [7:0] rxByte;
  strobe_t stb;

  i2cs_sync #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclF(sclF), .sdaF(sdaF), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet));

  i2cs_ctrl #(.ADDR_BASE(ADDR_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .sdaF(sdaF), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .strapSel(strapSel),
    .rxByte(rxByte), .txBit(txBit), .stb(stb), .sdaOe(sdaOe), .hsMode(hsMode));

  i2cs_data #(.NREG(NREG), .REG_INIT(REG_INIT)) u_data (
    .clk(clk), .rstN(rstN), .sdaF(sdaF), .stb(stb), .rxByte(rxByte),
    .txBit(txBit), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .powerDown(powerDown));
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
  input logic clk,
  input logic rstN,
  input logic sclF,
  input logic stopDet,
  input logic sdaOe,
  input logic hsMode,
  input logic regWrEn,
  input logic powerDown
);
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclF); // R9
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe); // R5
  AST_HS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !hsMode); // R8
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn); // R3
  AST_PD_WR: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !powerDown); // R7
endmodule

bind i2cs_top i2cs_chk u_chk (
  .clk(clk), .rstN(rstN), .sclF(sclF), .stopDet(stopDet), .sdaOe(sdaOe),
  .hsMode(hsMode), .regWrEn(regWrEn), .powerDown(powerDown));

// File: tb/tb_i2cs_top.sv
module tb_i2cs_top;
  localparam int Q = 10;

  logic clk = 1'b0, rstN = 1'b0, scl = 1'b1, msda = 1'b1;
  logic [1:0] strap = 2'd0;
  logic sdaOe, hsMode, powerDown, regWrEn;
  logic [1:0] regWrAddr;
  logic [15:0] regWrData;
  wire sdaBus = msda & ~sdaOe;

  int total = 0, bad = 0, wrCount = 0, oeViol = 0;
  logic [1:0]  lastWrAddr;
  logic [15:0] lastWrData;
  logic [15:0] model [4];
  logic prevOe = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2cs_top dut (.clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus),
    .strapSel(strap), .sdaOe(sdaOe), .hsMode(hsMode), .powerDown(powerDown),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData));

  always @(negedge clk) begin
    if (regWrEn) begin
      wrCount++; lastWrAddr = regWrAddr; lastWrData = regWrData;
    end
    if (sdaOe != prevOe && scl) oeViol++;
    prevOe = sdaOe;
  end

  function automatic logic [15:0] initVal(input int k);
    return 16'h0A05 + 16'(k) * 16'h1010;
  endfunction

  function automatic logic [6:0] devAddr(input logic [1:0] s);
    return {5'b10010, s};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    waitQ(); msda = 1'b1; waitQ(); scl = 1'b1; waitQ(); msda = 1'b0; waitQ(); scl = 1'b0;
  endtask

  task automatic busStop();
    waitQ(); msda = 1'b0; waitQ(); scl = 1'b1; waitQ(); msda = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      waitQ(); msda = b[i]; waitQ(); scl = 1'b1; waitQ(); waitQ(); scl = 1'b0;
    end
    waitQ(); msda = 1'b1; waitQ(); scl = 1'b1; waitQ(); ack = !sdaBus; waitQ(); scl = 1'b0;
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      waitQ(); msda = 1'b1; waitQ(); scl = 1'b1; waitQ(); b[i] = sdaBus; waitQ(); scl = 1'b0;
    end
    waitQ(); msda = !giveAck; waitQ(); scl = 1'b1; waitQ(); waitQ(); scl = 1'b0;
  endtask

  task automatic setPtr(input logic [1:0] p, output logic ok);
    logic a0, a1;
    busStart(); sendByte({devAddr(strap), 1'b0}, a0); sendByte({6'd0, p}, a1); busStop();
    ok = a0 & a1;
  endtask

  task automatic writeReg(input logic [1:0] p, input logic [15:0] v, output logic [3:0] acks);
    logic a3, a2, a1, a0;
    busStart();
    sendByte({devAddr(strap), 1'b0}, a3); sendByte({6'd0, p}, a2);
    sendByte(v[15:8], a1); sendByte(v[7:0], a0);
    busStop();
    acks = {a3, a2, a1, a0};
  endtask

  task automatic readReg(output logic [15:0] v, output logic ok);
    logic [7:0] hi, lo;
    busStart(); sendByte({devAddr(strap), 1'b1}, ok);
    recvByte(1'b1, hi); recvByte(1'b0, lo); busStop();
    v = {hi, lo};
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ok, a, b;
    logic [15:0] v;
    logic [3:0] acks;
    logic [7:0] byt;
    int wc;
    for (int k = 0; k < 4; k++) model[k] = initVal(k);
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset state
    chk(!sdaOe && !hsMode && !powerDown && !regWrEn, "R10 outputs idle after reset",
        {sdaOe, hsMode, powerDown, regWrEn}, 0);
    readReg(v, ok);
    chk(ok && v == initVal(0), "R10 pointer 0 at reset reads reg0 init", v, initVal(0));
    for (int p = 1; p < 4; p++) begin
      setPtr(p[1:0], ok);
      readReg(v, b);
      chk(ok && b && v == initVal(p), "R10 R2 reset value via pointer", v, initVal(p));
    end

    // R1 strap decode sweep
    for (int s = 0; s < 4; s++) begin
      strap = s[1:0];
      for (int c = 0; c < 4; c++) begin
        busStart(); sendByte({5'b10010, c[1:0], 1'b0}, a); busStop();
        chk(a == (c == s), "R1 address acknowledge per strap", {s[7:0], c[7:0], 7'd0, a}, (c == s));
      end
    end
    busStart(); sendByte({7'h50, 1'b0}, a); busStop();
    chk(!a, "R1 foreign address not acknowledged", a, 0);

    // R3 R4 write and read sweep over strap and pointer
    for (int s = 0; s < 4; s++) begin
      strap = s[1:0];
      for (int p = 0; p < 4; p++) begin
        logic [15:0] val;
        val = 16'h1357 * 16'(s * 4 + p + 1);
        wc = wrCount;
        writeReg(p[1:0], val, acks);
        model[p] = val;
        chk(acks == 4'hF, "R3 all write bytes acknowledged", acks, 4'hF);
        chk(wrCount == wc + 1 && lastWrAddr == p[1:0] && lastWrData == val,
            "R3 write strobe address and data", {lastWrAddr, lastWrData}, {p[1:0], val});
        readReg(v, ok);
        chk(ok && v == val, "R4 read returns high byte then low byte", v, val);
      end
    end
    strap = 2'd1;

    // R2 pointer-only write keeps registers
    wc = wrCount;
    setPtr(2'd1, ok);
    chk(ok && wrCount == wc, "R2 pointer-only write makes no register write", wrCount, wc);
    readReg(v, ok);
    chk(v == model[1], "R2 pointer persists into later read", v, model[1]);
    readReg(v, ok);
    chk(v == model[1], "R2 pointer persists across two reads", v, model[1]);

    // R3 extra byte refused
    busStart(); sendByte({devAddr(strap), 1'b0}, a); sendByte(8'd2, a);
    sendByte(8'hBE, a); sendByte(8'hEF, a); sendByte(8'h77, b); busStop();
    model[2] = 16'hBEEF;
    chk(!b, "R3 fifth write byte not acknowledged", b, 0);
    readReg(v, ok);
    chk(v == 16'hBEEF, "R3 register holds only the two data bytes", v, 16'hBEEF);

    // R5 read cut short by missing acknowledge
    busStart(); sendByte({devAddr(strap), 1'b1}, a); recvByte(1'b0, byt);
    chk(byt == model[2][15:8], "R5 high byte before controller NACK", byt, model[2][15:8]);
    chk(!sdaOe, "R5 SDA released after NACK", sdaOe, 0);
    busStop();
    readReg(v, ok);
    chk(ok && v == model[2], "R5 next read works after cut-short read", v, model[2]);

    // R11 repeated START after pointer byte
    busStart(); sendByte({devAddr(strap), 1'b0}, a); sendByte(8'd3, b);
    busStart(); sendByte({devAddr(strap), 1'b1}, ok);
    recvByte(1'b1, v[15:8]); recvByte(1'b0, v[7:0]); busStop();
    chk(a && b && ok && v == model[3], "R11 repeated START restarts address phase", v, model[3]);

    // R8 high-speed master codes
    for (int x = 0; x < 8; x++) begin
      busStart(); sendByte({5'b00001, x[2:0]}, a);
      chk(!a && hsMode, "R8 code not acknowledged and mode set", {a, hsMode}, 2'b01);
      if (x == 7) begin
        busStart(); sendByte({devAddr(strap), 1'b1}, ok);
        recvByte(1'b0, byt);
        chk(ok && hsMode, "R8 address accepted after code with mode held", {ok, hsMode}, 2'b11);
      end
      busStop();
      chk(!hsMode, "R8 STOP clears mode", hsMode, 0);
    end

    // R6 R7 general call
    busStart(); sendByte(8'h01, a); busStop();
    chk(!a, "R6 general call with read bit not acknowledged", a, 0);
    busStart(); sendByte(8'h00, a); sendByte(8'h05, b); busStop();
    chk(a && !b && !powerDown, "R6 unknown general-call byte refused", {a, b, powerDown}, 3'b100);
    readReg(v, ok);
    chk(v == model[3], "R6 unknown byte leaves registers", v, model[3]);
    wc = wrCount;
    busStart(); sendByte(8'h00, a); sendByte(8'h06, b); busStop();
    chk(a && b && powerDown, "R6 reset command acknowledged, power-down set", {a, b, powerDown}, 3'b111);
    chk(wrCount == wc, "R6 reset command makes no write strobe", wrCount, wc);
    readReg(v, ok);
    chk(v == initVal(0), "R6 pointer back to 0 with reset value", v, initVal(0));
    for (int p = 1; p < 4; p++) begin
      setPtr(p[1:0], ok); readReg(v, ok);
      chk(v == initVal(p), "R6 register back to reset value", v, initVal(p));
    end
    chk(powerDown, "R7 power-down holds across reads", powerDown, 1);
    writeReg(2'd0, 16'h4242, acks);
    chk(!powerDown && lastWrData == 16'h4242, "R7 register write clears power-down", powerDown, 0);

    // R9 drive changes only while SCL low
    chk(oeViol == 0, "R9 sdaOe changed while SCL high", oeViol, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule